// File: doc/BRIEF.md
# Strided Gather Payload Packer

This block sits next to one local memory bank and runs a single gather thread. A start handshake delivers a descriptor with three parts: a base address, a stride and an element count. The engine then reads the selected 64-bit elements from its own bank and packs them, in the order it reads them, into a payload buffer of Q words.

When the buffer is full, the engine presents it as one message on a valid/ready output, and gathering carries on into an empty buffer. After the last element, any partly filled buffer goes out with its real word count and a last flag. The gathered elements therefore end up as a compact vector spread across a series of fixed-size messages.

When the receiver applies backpressure, the engine stops issuing memory reads, so no element is lost or read twice.

Top module: `gather_packer`

## Requirements
- R1: A descriptor is taken on a clock edge where `start_valid` and `start_ready` are both high. `start_ready` is high exactly when the engine is idle. A start offered while busy is not taken and has no effect on the gather in progress.
- R2: Element i is read from address `base + i*stride`. The stride counts 64-bit words and the sum wraps modulo 2^AW. Each element gets exactly one `mem_rd_en` cycle, and elements are read in ascending i. Read data is returned one cycle after `mem_rd_en`.
- R3: Inside a payload, the k-th element placed there sits in `out_data[k*DW +: DW]`, so word 0 is in the least significant bits. Elements keep gather order across payloads.
- R4: When Q elements have been packed, the payload is presented with `out_count` = Q. After it is accepted, packing continues into an empty buffer.
- R5: After the final element, a partly filled payload is presented with `out_count` equal to the number of words it holds. Its unused words are zero.
- R6: `out_last` is 1 only on the final payload of a gather, including a final payload that happens to be full. Any payload with `out_count` < Q carries `out_last` = 1.
- R7: A count of zero issues no read and sends no payload. It pulses `done` in the cycle after acceptance, and `busy` stays low.
- R8: While `out_valid` is high and `out_ready` is low, the payload, count and last flag hold steady and no memory read is issued.
- R9: For a non-zero count, `busy` is high from the cycle after acceptance until the final payload is accepted. `done` is then high for one cycle, in the same cycle that `busy` returns low.
- R10: After reset, `busy`, `done`, `out_valid` and `mem_rd_en` are low and `start_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Descriptor offered |
| start_ready | output | 1 | Engine idle, descriptor can be taken |
| start_base | input | AW | Address of element 0 |
| start_stride | input | AW | Word distance between elements |
| start_count | input | CW | Number of elements |
| mem_rd_en | output | 1 | Read request to local bank |
| mem_rd_addr | output | AW | Read address |
| mem_rd_data | input | DW | Read data, one cycle after request |
| out_valid | output | 1 | Payload presented |
| out_ready | input | 1 | Receiver takes payload |
| out_data | output | Q*DW | Payload words, word 0 lowest |
| out_count | output | $clog2(Q+1) | Valid words in payload |
| out_last | output | 1 | Final payload of the gather |
| busy | output | 1 | Gather in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The in-line properties check, on every cycle, the things that hold locally. A held payload stays stable under backpressure. No read is issued while a payload waits. Any count below Q comes with the last flag. The step counter never steps past zero, and `done` only appears with the engine idle.

Some behaviour needs whole scenarios and an independent reference, and only the bench can show it. This covers the address sequence under wrap-around, zero and all-ones strides, the word order inside payloads, the split of a gather into full and partial messages, the zero-count case, and a start offered while busy being ignored.

// File: rtl/gp_pkg.sv
package gp_pkg;
    typedef enum logic {
        GP_IDLE = 1'b0,
        GP_RUN  = 1'b1
    } gp_state_e;
endpackage

// File: rtl/gp_addr_gen.sv
// Element address walker: holds the current address and the remaining element count.
module gp_addr_gen #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] stride,
    input  logic [CW-1:0] count,
    output logic [AW-1:0] addr,
    output logic          more,
    output logic          final_elem
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] stride;
        logic [CW-1:0] rem;
    } ag_t;

    ag_t ag_d, ag_q;

    always_comb begin
        ag_d = ag_q;
        if (load) begin
            ag_d.addr   = base;
            ag_d.stride = stride;
            ag_d.rem    = count;
        end else if (step) begin
            ag_d.addr = ag_q.addr + ag_q.stride;
            ag_d.rem  = ag_q.rem - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ag_q <= '0;
        else        ag_q <= ag_d;
    end

    assign addr       = ag_q.addr;
    assign more       = (ag_q.rem != '0);
    assign final_elem = (ag_q.rem == CW'(1));

    // R2: a read is only issued while elements remain
    a_r2_step_has_work: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (ag_q.rem != '0));
endmodule

// File: rtl/gp_pack_buf.sv
// Payload buffer that doubles as the output register.
module gp_pack_buf #(
    parameter int DW   = 64,
    parameter int Q    = 4,
    parameter int CNTW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic            wr_last,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [Q*DW-1:0] out_data,
    output logic [CNTW-1:0] out_count,
    output logic            out_last,
    output logic            at_top
);
    localparam int IDXW = (Q > 1) ? $clog2(Q) : 1;

    typedef struct packed {
        logic [Q-1:0][DW-1:0] words;
        logic [CNTW-1:0]      fill;
        logic                 vld;
        logic                 last;
    } pb_t;

    pb_t pb_d, pb_q;
    logic [IDXW-1:0] idx;

    assign idx = pb_q.fill[IDXW-1:0];

    always_comb begin
        pb_d = pb_q;
        if (pb_q.vld && out_ready) begin
            pb_d = '0;
        end else if (wr_en) begin
            pb_d.words[idx] = wr_data;
            pb_d.fill       = pb_q.fill + CNTW'(1);
            if ((pb_q.fill == CNTW'(Q - 1)) || wr_last) begin
                pb_d.vld  = 1'b1;
                pb_d.last = wr_last;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pb_q <= '0;
        else        pb_q <= pb_d;
    end

    assign out_valid = pb_q.vld;
    assign out_data  = pb_q.words;
    assign out_count = pb_q.fill;
    assign out_last  = pb_q.last;
    assign at_top    = (pb_q.fill == CNTW'(Q - 1));

    a_r8_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_count) && $stable(out_last)));
    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_count != '0) && (out_count <= CNTW'(Q))));
    a_r6_short_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_count != CNTW'(Q))) |-> out_last);
endmodule

// File: rtl/gather_packer.sv
module gather_packer
    import gp_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 64,
    parameter int Q    = 4,
    parameter int CW   = 16,
    localparam int CNTW = $clog2(Q + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_valid,
    output logic            start_ready,
    input  logic [AW-1:0]   start_base,
    input  logic [AW-1:0]   start_stride,
    input  logic [CW-1:0]   start_count,
    output logic            mem_rd_en,
    output logic [AW-1:0]   mem_rd_addr,
    input  logic [DW-1:0]   mem_rd_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [Q*DW-1:0] out_data,
    output logic [CNTW-1:0] out_count,
    output logic            out_last,
    output logic            busy,
    output logic            done
);
    typedef struct packed {
        gp_state_e st;
        logic      pend;
        logic      pend_last;
        logic      done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic start_fire, issue, more, final_elem, at_top, finish;

    assign start_ready = (ctl_q.st == GP_IDLE);
    assign start_fire  = start_valid && start_ready;
    assign issue       = (ctl_q.st == GP_RUN) && more && !out_valid
                         && !(ctl_q.pend && at_top);
    assign finish      = out_valid && out_ready && out_last;

    gp_addr_gen #(.AW(AW), .CW(CW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_fire),
        .step       (issue),
        .base       (start_base),
        .stride     (start_stride),
        .count      (start_count),
        .addr       (mem_rd_addr),
        .more       (more),
        .final_elem (final_elem)
    );

    gp_pack_buf #(.DW(DW), .Q(Q), .CNTW(CNTW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctl_q.pend),
        .wr_data   (mem_rd_data),
        .wr_last   (ctl_q.pend_last),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_count (out_count),
        .out_last  (out_last),
        .at_top    (at_top)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.pend      = issue;
        ctl_d.pend_last = issue && final_elem;
        ctl_d.done      = 1'b0;
        case (ctl_q.st)
            GP_IDLE: begin
                if (start_fire) begin
                    if (start_count == '0) ctl_d.done = 1'b1;
                    else                   ctl_d.st   = GP_RUN;
                end
            end
            GP_RUN: begin
                if (finish) begin
                    ctl_d.st   = GP_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = GP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: GP_IDLE, pend: 1'b0, pend_last: 1'b0, done: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign mem_rd_en = issue;
    assign busy      = (ctl_q.st == GP_RUN);
    assign done      = ctl_q.done;

    a_r8_no_read_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_rd_en);
    a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !out_valid));
    a_r9_busy_until_final: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> busy);
endmodule

// File: tb/gather_packer_bench.sv
module gather_packer_bench;
    localparam int AW = 16;
    localparam int DW = 64;
    localparam int Q  = 4;
    localparam int CW = 16;
    localparam int CNTW = $clog2(Q + 1);

    typedef struct {
        logic [Q*DW-1:0] data;
        int              cnt;
        bit              last;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_valid = 1'b0;
    logic start_ready;
    logic [AW-1:0] start_base = '0;
    logic [AW-1:0] start_stride = '0;
    logic [CW-1:0] start_count = '0;
    logic mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [DW-1:0] mem_rd_data = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [Q*DW-1:0] out_data;
    logic [CNTW-1:0] out_count;
    logic out_last;
    logic busy;
    logic done;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    int stall_mode = 0;
    bit done_flag = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    exp_t exp_q[$];
    logic [AW-1:0] addr_q[$];
    bit held_prev = 1'b0;
    logic [Q*DW-1:0] held_data;

    gather_packer #(.AW(AW), .DW(DW), .Q(Q), .CW(CW)) u_gather_packer (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_base(start_base), .start_stride(start_stride), .start_count(start_count),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_count(out_count), .out_last(out_last), .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return {16'hBEEF, a, ~a, a ^ 16'h5A5A};
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_val(mem_rd_addr);

    task automatic check(input bit ok, input string req, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Monitor: everything sampled at the falling edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
            finish_run();
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rst_n) begin
            // R8: a payload held under backpressure stays put and reads stop
            if (held_prev) begin
                check(out_valid && out_data == held_data && !mem_rd_en, "R8",
                      $sformatf("held payload changed or read issued: valid=%0b rd=%0b exp valid=1 rd=0",
                                out_valid, mem_rd_en));
            end
            if (mem_rd_en) begin
                if (addr_q.size() == 0) begin
                    check(1'b0, "R2", $sformatf("unexpected read addr=%h expected none", mem_rd_addr));
                end else begin
                    logic [AW-1:0] ea;
                    ea = addr_q.pop_front();
                    check(mem_rd_addr == ea, "R2",
                          $sformatf("read addr actual=%h expected=%h", mem_rd_addr, ea));
                end
            end
            out_ready = (stall_mode != 0) ? (lfsr[0] & lfsr[3]) : 1'b1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected payload, expected none");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    // R3 word order, R4/R5 count, R6 last flag, R5 zero fill
                    check(out_data == e.data && int'(out_count) == e.cnt && out_last == e.last,
                          "R3 R4 R5 R6",
                          $sformatf("payload actual cnt=%0d last=%0b data=%h expected cnt=%0d last=%0b data=%h",
                                    out_count, out_last, out_data, e.cnt, e.last, e.data));
                end
            end
            held_prev = out_valid && !out_ready;
            held_data = out_data;
            if (done) done_flag = 1'b1;
        end
    end

    task automatic run_gather(input logic [AW-1:0] b, input logic [AW-1:0] s,
                              input int n, input int stall, input bit intrude);
        logic [Q*DW-1:0] cur;
        int k;
        cur = '0;
        k = 0;
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] a;
            a = b + AW'(i) * s;
            addr_q.push_back(a);
            cur[k*DW +: DW] = mem_val(a);
            k++;
            if (k == Q || i == n - 1) begin
                exp_q.push_back('{data: cur, cnt: k, last: (i == n - 1)});
                cur = '0;
                k = 0;
            end
        end
        stall_mode = stall;
        done_flag = 1'b0;
        @(negedge clk);
        check(start_ready == 1'b1 && busy == 1'b0, "R1",
              $sformatf("idle ready=%0b busy=%0b expected 1/0", start_ready, busy));
        start_valid = 1'b1;
        start_base = b;
        start_stride = s;
        start_count = CW'(n);
        @(negedge clk);
        start_valid = 1'b0;
        if (n == 0) begin
            check(done == 1'b1 && busy == 1'b0 && !out_valid, "R7",
                  $sformatf("zero count done=%0b busy=%0b valid=%0b expected 1/0/0", done, busy, out_valid));
            @(negedge clk);
            check(done == 1'b0, "R7", $sformatf("done pulse length actual=%0b expected 0", done));
        end else begin
            check(busy == 1'b1 && start_ready == 1'b0, "R9",
                  $sformatf("after start busy=%0b ready=%0b expected 1/0", busy, start_ready));
            if (intrude) begin
                // R1: a start offered while busy must not be taken
                start_valid = 1'b1;
                start_base = 16'h0BAD;
                start_stride = 16'h0001;
                start_count = CW'(3);
                repeat (4) @(negedge clk);
                start_valid = 1'b0;
            end
            while (!done_flag) @(negedge clk);
            check(busy == 1'b0 && start_ready == 1'b1, "R9",
                  $sformatf("at done busy=%0b ready=%0b expected 0/1", busy, start_ready));
            @(negedge clk);
            check(done == 1'b0, "R9", $sformatf("done pulse length actual=%0b expected 0", done));
        end
        check(exp_q.size() == 0 && addr_q.size() == 0, "R2 R5",
              $sformatf("left over payloads=%0d reads=%0d expected 0/0", exp_q.size(), addr_q.size()));
        repeat (3) @(negedge clk);
        check(addr_q.size() == 0 && !out_valid, "R1",
              $sformatf("activity after gather valid=%0b expected 0", out_valid));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!busy && !done && !out_valid && !mem_rd_en && start_ready, "R10",
              $sformatf("reset busy=%0b done=%0b valid=%0b rd=%0b ready=%0b expected 0/0/0/0/1",
                        busy, done, out_valid, mem_rd_en, start_ready));
        rst_n = 1'b1;
        run_gather(16'h0100, 16'h0001, 10, 0, 1'b0);
        run_gather(16'h0020, 16'h0003, 8, 1, 1'b0);
        run_gather(16'h0007, 16'h0009, 1, 1, 1'b0);
        run_gather(16'h0040, 16'h0002, 0, 0, 1'b0);
        run_gather(16'hFFF0, 16'h0007, 9, 1, 1'b0);
        run_gather(16'h1234, 16'h0000, 5, 0, 1'b0);
        run_gather(16'h0010, 16'hFFFF, 6, 1, 1'b1);
        run_gather(16'h0300, 16'h0002, 13, 1, 1'b1);
        run_gather(16'h0500, 16'h0004, 4, 0, 1'b0);
        finish_run();
    end
endmodule